// File: doc/BRIEF.md
# Serial Port Enable and Framing Control Register

This block holds the eight control bits of an asynchronous serial port and turns them into qualified control signals for the separate transmit and receive engines. Software reaches the register through a byte-wide write port, a single-bit write port and a byte-wide readback. The power bit gates the whole port. While it is clear, both engines are held in reset and the serial output sits at its idle level. That level is high, or low when the `idle_invert` input is set.

Each direction has its own enable gate. It is a small state machine with three states: `GATE_OFF`, `GATE_SETTLE` and `GATE_LIVE`. The transitions are:
- `GATE_OFF` to `GATE_SETTLE` when power and the direction enable are both set.
- `GATE_SETTLE` to `GATE_LIVE` after `ENABLE_DELAY` clock cycles have passed since that request.
- Any state back to `GATE_OFF` as soon as the request drops.

The qualified enable output is forced low the moment the request drops. The engine is therefore held in reset through the whole window in which software clears and later re-sets the bit. Start-bit detections from the receive engine are passed on only while reception is qualified. The direction, parity, character-length and stop-length fields go straight to the framing engines.

Top module: `uartctl_top`

## Requirements
- R1: After reset the register reads 0x10. `reg_rdata` always shows the stored register value and never the delayed enable state.
- R2: A byte write (`reg_byte_we`) replaces all eight bits with `reg_wdata`. The bit positions are: bit 7 power, bit 6 transmit enable, bit 5 receive enable, bit 4 direction, bits 3:2 parity, bit 1 character length, bit 0 stop length.
- R3: A bit write (`reg_bit_we`) sets bit `reg_bit_sel` to `reg_wdata[0]` and leaves the other seven bits unchanged. When both strobes are high in the same cycle, the byte write wins.
- R4: While the power bit is 0, `port_rst_n`, `tx_active` and `rx_active` are low and `txd` equals the inverse of `idle_invert`. While the power bit is 1, `port_rst_n` is high and `txd` follows `txd_from_eng`.
- R5: `tx_active` goes high two clock cycles after the edge that first makes power and transmit enable both 1, and stays high while both stay 1.
- R6: `rx_active` obeys the same two-cycle rule for power and receive enable.
- R7: Clearing a direction enable or the power bit drops that direction's qualified enable in the same cycle the register changes. Setting it again restarts the full two-cycle delay.
- R8: `rx_start_ok` equals `rx_start_det` when `rx_active` is high and is 0 otherwise. Start bits before qualification are ignored.
- R9: `cfg_dir`, `cfg_parity`, `cfg_char_len` and `cfg_stop_len` equal register bits 4, 3:2, 1 and 0 at all times.
- R10: A direction enable set while power is 0 has no effect. Its delay counts from the write that sets power.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_byte_we | input | 1 | Whole-byte write strobe |
| reg_bit_we | input | 1 | Single-bit write strobe |
| reg_bit_sel | input | 3 | Bit position for a bit write |
| reg_wdata | input | 8 | Write data (bit 0 is the value for a bit write) |
| reg_rdata | output | 8 | Stored register value |
| idle_invert | input | 1 | Selects a low idle level on the serial output |
| txd_from_eng | input | 1 | Serial data from the transmit engine |
| txd | output | 1 | Serial output pin |
| rx_start_det | input | 1 | Raw start-bit detection from the receive engine |
| rx_start_ok | output | 1 | Start detection qualified by reception enable |
| port_rst_n | output | 1 | Engine reset, low while power bit is 0 |
| tx_active | output | 1 | Delayed transmit enable (engine held in reset while low) |
| rx_active | output | 1 | Delayed receive enable (engine held in reset while low) |
| cfg_dir | output | 1 | Bit-order select |
| cfg_parity | output | 2 | Parity mode |
| cfg_char_len | output | 1 | Character length select |
| cfg_stop_len | output | 1 | Stop length select |

## Verification
A gate stuck in `GATE_SETTLE` or `GATE_LIVE` shows at the ports within one cycle of the reference's change. It appears as `tx_active` or `rx_active` rising a cycle early or late, or staying high after the enable bit is cleared. It also leaks through `rx_start_ok`. A corrupted stored bit appears at once on `reg_rdata`, on the matching `cfg_*` output, or in the `txd` idle level. The reference model is compared on every cycle, so any divergence is caught in the cycle where it first appears.

// File: rtl/uartctl_pkg.sv
package uartctl_pkg;

    localparam int CTRL_W      = 8;
    localparam int BIT_PWR     = 7;
    localparam int BIT_TXE     = 6;
    localparam int BIT_RXE     = 5;
    localparam int BIT_DIR     = 4;
    localparam int BIT_PAR_LO  = 2;
    localparam int BIT_CLEN    = 1;
    localparam int BIT_SLEN    = 0;
    localparam int N_DIRS      = 2;
    localparam int DIR_TX      = 0;
    localparam int DIR_RX      = 1;

    localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h10;

    typedef enum logic [1:0] {
        GATE_OFF    = 2'd0,
        GATE_SETTLE = 2'd1,
        GATE_LIVE   = 2'd2
    } gate_state_e;

    typedef struct packed {
        logic       dir;
        logic [1:0] parity;
        logic       clen;
        logic       slen;
    } frame_cfg_t;

endpackage

// File: rtl/uartctl_reg.sv
module uartctl_reg #(
    parameter int              W     = 8,
    parameter logic [W-1:0]    RESET = '0,
    localparam int             SW    = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_we,
    input  logic [W-1:0]  byte_data,
    input  logic          bit_we,
    input  logic [SW-1:0] bit_idx,
    input  logic          bit_val,
    output logic [W-1:0]  q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RESET;
        end else if (byte_we) begin
            q <= byte_data;
        end else if (bit_we) begin
            q[bit_idx] <= bit_val;
        end
    end

    // R2: a byte write lands whole
    a_r2_byte_write: assert property (@(posedge clk) disable iff (!rst_n)
        byte_we |=> (q == $past(byte_data)));

    // R3: a bit write touches no other bit
    a_r3_bit_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_we && !byte_we) |=>
            (((q ^ $past(q)) & ~(W'(1) << $past(bit_idx))) == '0));

    // R3: the selected bit takes the written value
    a_r3_bit_value: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_we && !byte_we) |=> (q[$past(bit_idx)] == $past(bit_val)));

endmodule

// File: rtl/uartctl_gate.sv
module uartctl_gate
    import uartctl_pkg::*;
#(
    parameter int  DELAY = 2,
    localparam int CW    = $clog2(DELAY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr,
    input  logic en,
    output logic active
);

    gate_state_e     state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic            req;

    assign req = pwr & en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GATE_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!req) begin
            state_d = GATE_OFF;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                GATE_OFF: begin
                    cnt_d   = CW'(1);
                    state_d = (DELAY <= 1) ? GATE_LIVE : GATE_SETTLE;
                end
                GATE_SETTLE: begin
                    if (cnt_q >= CW'(DELAY - 1)) begin
                        state_d = GATE_LIVE;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                GATE_LIVE: begin
                    state_d = GATE_LIVE;
                end
                default: begin
                    state_d = GATE_OFF;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_comb begin
        active = 1'b0;
        unique case (state_q)
            GATE_OFF:    active = 1'b0;
            GATE_SETTLE: active = 1'b0;
            GATE_LIVE:   active = req;
            default:     active = 1'b0;
        endcase
    end

    // Independent run-length counter used only by the checks
    logic [CW-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!req) begin
            run_q <= '0;
        end else if (run_q < CW'(DELAY)) begin
            run_q <= run_q + CW'(1);
        end
    end

    // R5: never qualified before the full delay
    a_r5_min_delay: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (run_q >= CW'(DELAY)));

    // R5: qualified as soon as the delay is over
    a_r5_no_extra_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (req && run_q == CW'(DELAY)) |-> active);

    // R7: a dropped request returns the gate to its off state
    a_r7_drop_resets: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (state_q == GATE_OFF));

    // R4: no qualification without power
    a_r4_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr |-> !active);

endmodule

// File: rtl/uartctl_top.sv
module uartctl_top
    import uartctl_pkg::*;
#(
    parameter int ENABLE_DELAY = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_byte_we,
    input  logic       reg_bit_we,
    input  logic [2:0] reg_bit_sel,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       idle_invert,
    input  logic       txd_from_eng,
    output logic       txd,
    input  logic       rx_start_det,
    output logic       rx_start_ok,
    output logic       port_rst_n,
    output logic       tx_active,
    output logic       rx_active,
    output logic       cfg_dir,
    output logic [1:0] cfg_parity,
    output logic       cfg_char_len,
    output logic       cfg_stop_len
);

    logic [CTRL_W-1:0] ctrl_q;
    logic [N_DIRS-1:0] dir_en;
    logic [N_DIRS-1:0] dir_active;
    logic              pwr;
    frame_cfg_t        fcfg;

    uartctl_reg #(
        .W     (CTRL_W),
        .RESET (CTRL_RESET)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_we   (reg_byte_we),
        .byte_data (reg_wdata),
        .bit_we    (reg_bit_we),
        .bit_idx   (reg_bit_sel),
        .bit_val   (reg_wdata[0]),
        .q         (ctrl_q)
    );

    assign pwr            = ctrl_q[BIT_PWR];
    assign dir_en[DIR_TX] = ctrl_q[BIT_TXE];
    assign dir_en[DIR_RX] = ctrl_q[BIT_RXE];

    for (genvar d = 0; d < N_DIRS; d++) begin : g_dir
        uartctl_gate #(
            .DELAY (ENABLE_DELAY)
        ) u_gate (
            .clk    (clk),
            .rst_n  (rst_n),
            .pwr    (pwr),
            .en     (dir_en[d]),
            .active (dir_active[d])
        );
    end

    assign fcfg.dir    = ctrl_q[BIT_DIR];
    assign fcfg.parity = ctrl_q[BIT_PAR_LO +: 2];
    assign fcfg.clen   = ctrl_q[BIT_CLEN];
    assign fcfg.slen   = ctrl_q[BIT_SLEN];

    assign reg_rdata    = ctrl_q;
    assign port_rst_n   = pwr;
    assign tx_active    = dir_active[DIR_TX];
    assign rx_active    = dir_active[DIR_RX];
    assign txd          = pwr ? txd_from_eng : ~idle_invert;
    assign rx_start_ok  = rx_start_det & dir_active[DIR_RX];
    assign cfg_dir      = fcfg.dir;
    assign cfg_parity   = fcfg.parity;
    assign cfg_char_len = fcfg.clen;
    assign cfg_stop_len = fcfg.slen;

    // R4: idle level while powered down
    a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !port_rst_n |-> (txd != idle_invert));

    // R4: engines off while powered down
    a_r4_engines_off: assert property (@(posedge clk) disable iff (!rst_n)
        !port_rst_n |-> (!tx_active && !rx_active));

    // R8: start detections masked until reception qualified
    a_r8_start_mask: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start_ok |-> rx_active);

endmodule

// File: tb/test_uartctl_top.sv
module test_uartctl_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_byte_we = 1'b0;
    logic       reg_bit_we = 1'b0;
    logic [2:0] reg_bit_sel = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       idle_invert = 1'b0;
    logic       txd_from_eng = 1'b0;
    logic       txd;
    logic       rx_start_det = 1'b0;
    logic       rx_start_ok;
    logic       port_rst_n;
    logic       tx_active;
    logic       rx_active;
    logic       cfg_dir;
    logic [1:0] cfg_parity;
    logic       cfg_char_len;
    logic       cfg_stop_len;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m_reg;
    int         m_txrun, m_rxrun;

    always #2 clk = ~clk;

    uartctl_top i_uartctl_top (
        .clk(clk), .rst_n(rst_n),
        .reg_byte_we(reg_byte_we), .reg_bit_we(reg_bit_we),
        .reg_bit_sel(reg_bit_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .idle_invert(idle_invert),
        .txd_from_eng(txd_from_eng), .txd(txd),
        .rx_start_det(rx_start_det), .rx_start_ok(rx_start_ok),
        .port_rst_n(port_rst_n), .tx_active(tx_active),
        .rx_active(rx_active), .cfg_dir(cfg_dir),
        .cfg_parity(cfg_parity), .cfg_char_len(cfg_char_len),
        .cfg_stop_len(cfg_stop_len)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit m_tx_act();
        return m_reg[7] && m_reg[6] && m_txrun >= 2;
    endfunction

    function automatic bit m_rx_act();
        return m_reg[7] && m_reg[5] && m_rxrun >= 2;
    endfunction

    task automatic model_edge();
        bit old_tx, old_rx, new_tx, new_rx;
        if (!rst_n) begin
            m_reg = 8'h10; m_txrun = 0; m_rxrun = 0;
            return;
        end
        old_tx = m_reg[7] & m_reg[6];
        old_rx = m_reg[7] & m_reg[5];
        if (reg_byte_we) m_reg = reg_wdata;
        else if (reg_bit_we) m_reg[reg_bit_sel] = reg_wdata[0];
        new_tx = m_reg[7] & m_reg[6];
        new_rx = m_reg[7] & m_reg[5];
        m_txrun = !new_tx ? 0 : (old_tx ? m_txrun + 1 : 0);
        m_rxrun = !new_rx ? 0 : (old_rx ? m_rxrun + 1 : 0);
        if (m_txrun > 4) m_txrun = 4;
        if (m_rxrun > 4) m_rxrun = 4;
    endtask

    task automatic compare_all();
        bit ta, ra;
        ta = m_tx_act();
        ra = m_rx_act();
        check("R1 readback", reg_rdata, m_reg);
        check("R4 port reset", port_rst_n, m_reg[7]);
        check("R4 txd level", txd, m_reg[7] ? txd_from_eng : !idle_invert);
        check("R5 tx_active", tx_active, ta);
        check("R6 rx_active", rx_active, ra);
        check("R8 start mask", rx_start_ok, rx_start_det & ra);
        check("R9 framing cfg", {cfg_dir, cfg_parity, cfg_char_len, cfg_stop_len}, m_reg[4:0]);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
        reg_byte_we = 1'b0;
        reg_bit_we  = 1'b0;
    endtask

    task automatic wbyte(logic [7:0] v);
        reg_byte_we = 1'b1; reg_wdata = v; step();
    endtask

    task automatic wbit(int idx, bit v);
        reg_bit_we = 1'b1; reg_bit_sel = 3'(idx); reg_wdata = {7'd0, v}; step();
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_reg = 8'h10; m_txrun = 0; m_rxrun = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 reset value", reg_rdata, 8'h10);
        check("R4 reset txd", txd, 1);
        check("R4 reset port", port_rst_n, 0);
        step();
        rst_n = 1'b1;
        step();

        // R10: enables before power do nothing
        wbit(6, 1);
        wbit(5, 1);
        step(); step();
        check("R10 tx off without power", tx_active, 0);
        idle_invert = 1'b1; #1;
        check("R4 inverted idle", txd, 0);
        idle_invert = 1'b0;

        // R10/R5: delay counts from power write
        wbit(7, 1);
        check("R5 after write", tx_active, 0);
        rx_start_det = 1'b1;
        step();
        check("R5 one cycle", tx_active, 0);
        check("R8 early start ignored", rx_start_ok, 0);
        step();
        check("R5 two cycles", tx_active, 1);
        check("R6 two cycles", rx_active, 1);
        check("R8 start passed", rx_start_ok, 1);
        rx_start_det = 1'b0;

        // R7: clear drops at once, re-set restarts
        wbit(6, 0);
        check("R7 tx cleared", tx_active, 0);
        step();
        wbit(6, 1);
        check("R7 restart 0", tx_active, 0);
        step();
        check("R7 restart 1", tx_active, 0);
        step();
        check("R7 restart 2", tx_active, 1);

        // R2 byte write and R3 priority
        wbyte(8'hAD);
        check("R2 byte", reg_rdata, 8'hAD);
        reg_bit_we = 1'b1; reg_bit_sel = 3'd3; reg_byte_we = 1'b1; reg_wdata = 8'h52;
        step();
        check("R3 byte wins", reg_rdata, 8'h52);
        wbit(0, 1);
        check("R3 bit0 set", reg_rdata, 8'h53);
        wbit(4, 0);
        check("R3 bit4 clear", reg_rdata, 8'h43);

        // R4: power off with enables still set
        wbyte(8'hE0); step(); step();
        wbit(7, 0);
        check("R4 power off tx", tx_active, 0);
        check("R4 power off rx", rx_active, 0);

        // Mixed stimulus against the model
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 9);
            idle_invert  = 1'($urandom_range(0, 1));
            txd_from_eng = 1'($urandom_range(0, 1));
            rx_start_det = 1'($urandom_range(0, 1));
            if (r == 0) begin
                reg_byte_we = 1'b1; reg_wdata = 8'($urandom_range(0, 255));
            end else if (r <= 3) begin
                reg_bit_we = 1'b1;
                reg_bit_sel = (r == 3) ? 3'($urandom_range(0, 7)) : 3'($urandom_range(5, 7));
                reg_wdata = 8'($urandom_range(0, 255));
                reg_byte_we = 1'($urandom_range(0, 15) == 0);
            end
            step();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule